// File: doc/BRIEF.md
# Oversampled Bit Clock and Data Recovery

This block takes a demodulated serial bit stream, already reduced to one logic level per sample, and rebuilds from it a bit clock and a retimed data bit. It runs from the crystal-derived system clock. A 7-bit rate code D sets the nominal bit period. Each bit window is split into 64 phase ticks. A prescaler that reloads itself produces one tick every D+1 system clocks, so a bit lasts 64*(D+1) clocks. For example, a 12.8 MHz system clock with D = 7 gives 25 kb/s.

The input bit passes through a two-flop synchronizer. Each level change of the synchronized bit is classed by the phase at which it arrives. A change in the first half of the window holds the phase counter back by one tick. A change in the second half moves it forward by one tick. Over time this keeps data transitions at the window boundary. The bit is sampled at mid-window, and the recovered clock rises at that moment.

A disable input turns recovery off. While it is set, the raw demodulated bit goes directly to the data output, the recovered clock stays at 0 and no valid pulses are produced.

Top module: `bitclk_recovery`

## Requirements
- R1: With no input transitions, successive rising edges of `dclk_out` are 64*(D+1) system clocks apart for a rate code D (tested at D = 0, 3, 7).
- R2: With D = 7 the bit period is 512 clocks, which gives 25 kb/s from a 12.8 MHz clock.
- R3: With no input transitions, `dclk_out` stays high for 32*(D+1) clocks of each bit period and low for the rest.
- R4: `bit_valid` is a one-clock pulse in the cycle where `dclk_out` rises. `data_out` does not change while `dclk_out` stays high.
- R5: When bits are sent with transitions near the window boundary, the value of `data_out` at each `bit_valid` equals the bit that was sent, for rate codes 0, 1, 2 and 5.
- R6: A transition that is detected while the phase is in ticks 1 to 31 retards the phase counter by one tick, so that bit period is longer by D+1 clocks.
- R7: A transition that is detected while the phase is in ticks 32 to 63 advances the phase counter by one tick, so that bit period is shorter by D+1 clocks.
- R8: A new rate code takes effect at the next bit boundary, which is where the phase wraps from 63 to 0. If D changes from 0 to 3 just after a rising edge of `dclk_out`, the next rise comes 32 + 32*4 = 160 clocks later.
- R9: While `recov_dis` is 1, `data_out` equals `din_raw` in the same cycle, and `dclk_out` and `bit_valid` are 0.
- R10: During reset, `dclk_out`, `bit_valid` and `data_out` are 0 (with `recov_dis` = 0 and `din_raw` = 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock derived from the crystal |
| rst_n | input | 1 | Asynchronous active-low reset |
| din_raw | input | 1 | Demodulated serial bit, asynchronous |
| rate_code | input | 7 | Rate code D; one tick is D+1 clocks |
| recov_dis | input | 1 | 1 = bypass recovery and pass raw data through |
| data_out | output | 1 | Retimed data, or the raw bit in bypass |
| dclk_out | output | 1 | Recovered bit clock; rises at mid-bit |
| bit_valid | output | 1 | One-clock strobe when a new bit has been sampled |

## Verification
The hardest case to reach from the ports is a single, isolated phase correction in a known half of the window. The loop moves by only one tick and otherwise stays silent. The stimulus holds the input steady and aligns to a rising or falling edge of the recovered clock. It then toggles the input a fixed number of clocks later, so that the transition is detected well inside the second half of the window or the first half. The rise-to-rise interval that contains the correction then has to be exactly one tick shorter or one tick longer. The rate-change boundary is reached the same way: the code is changed right after a rise, and the expected interval mixes the old tick length and the new one.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int unsigned RATE_W = 7;
  localparam int unsigned PH_W   = 6;

  typedef enum logic [1:0] {
    ADJ_NONE    = 2'd0,
    ADJ_RETARD  = 2'd1,
    ADJ_ADVANCE = 2'd2
  } adj_e;
endpackage

// File: rtl/bcr_sync.sv
module bcr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic sync_bit,
  output logic edge_pulse
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign sync_bit   = chain_q[STAGES-1];
  assign edge_pulse = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/bcr_prescaler.sv
module bcr_prescaler #(
  parameter int unsigned RATE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              reload,
  output logic              tick
);
  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic [RATE_W-1:0] div_q, div_d;
  logic              primed_q;
  logic              load;

  always_comb begin
    tick  = primed_q && (cnt_q == div_q);
    load  = reload || !primed_q;
    div_d = div_q;
    cnt_d = tick ? '0 : cnt_q + RATE_W'(1);
    if (load) begin
      div_d = rate_code;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      div_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      div_q    <= div_d;
      primed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/bcr_phase.sv
module bcr_phase
  import bcr_pkg::*;
#(
  parameter int unsigned PH_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            edge_pulse,
  output logic [PH_W-1:0] phase,
  output logic            boundary,
  output logic            sample
);
  logic [PH_W-1:0] ph_q, ph_d;
  adj_e            adj_q, adj_d, cls, adj_now;

  always_comb begin
    cls = ADJ_NONE;
    if (edge_pulse && (ph_q != '0))
      cls = ph_q[PH_W-1] ? ADJ_ADVANCE : ADJ_RETARD;
    adj_now = edge_pulse ? cls : adj_q;

    ph_d  = ph_q;
    adj_d = adj_now;
    if (tick) begin
      adj_d = ADJ_NONE;
      unique case (adj_now)
        ADJ_RETARD:  ph_d = ph_q;
        ADJ_ADVANCE: ph_d = ph_q + PH_W'(2);
        default:     ph_d = ph_q + PH_W'(1);
      endcase
    end

    boundary = tick &&  ph_q[PH_W-1] && !ph_d[PH_W-1];
    sample   = tick && !ph_q[PH_W-1] &&  ph_d[PH_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      adj_q <= ADJ_NONE;
    end else begin
      ph_q  <= ph_d;
      adj_q <= adj_d;
    end
  end

  assign phase = ph_q;
endmodule

// File: rtl/bitclk_recovery.sv
module bitclk_recovery
  import bcr_pkg::*;
#(
  parameter int unsigned RATE_BITS   = RATE_W,
  parameter int unsigned PHASE_BITS  = PH_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 din_raw,
  input  logic [RATE_BITS-1:0] rate_code,
  input  logic                 recov_dis,
  output logic                 data_out,
  output logic                 dclk_out,
  output logic                 bit_valid
);
  logic                  sync_bit, edge_pulse, tick, boundary, sample;
  logic [PHASE_BITS-1:0] phase;
  logic                  data_q, data_d, valid_q, valid_d;

  bcr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(din_raw),
    .sync_bit(sync_bit), .edge_pulse(edge_pulse)
  );

  bcr_prescaler #(.RATE_W(RATE_BITS)) u_presc (
    .clk(clk), .rst_n(rst_n), .rate_code(rate_code),
    .reload(boundary), .tick(tick)
  );

  bcr_phase #(.PH_W(PHASE_BITS)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick), .edge_pulse(edge_pulse),
    .phase(phase), .boundary(boundary), .sample(sample)
  );

  always_comb begin
    data_d  = sample ? sync_bit : data_q;
    valid_d = sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign dclk_out  = !recov_dis && phase[PHASE_BITS-1];
  assign bit_valid = !recov_dis && valid_q;
  assign data_out  = recov_dis ? din_raw : data_q;
endmodule

// File: rtl/bcr_chk.sv
module bcr_chk (
  input logic clk,
  input logic rst_n,
  input logic recov_dis,
  input logic dclk_out,
  input logic bit_valid,
  input logic data_out
);
  // R9
  bypass_dclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recov_dis |-> !dclk_out);

  // R9
  bypass_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recov_dis |-> !bit_valid);

  // R4
  rise_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!recov_dis && !$past(recov_dis) && $rose(dclk_out)) |-> bit_valid);

  // R4
  valid_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> dclk_out);

  // R4
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!recov_dis && !$past(recov_dis) && dclk_out && !bit_valid) |-> $stable(data_out));
endmodule

bind bitclk_recovery bcr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .recov_dis(recov_dis),
  .dclk_out(dclk_out), .bit_valid(bit_valid), .data_out(data_out)
);

// File: tb/bitclk_recovery_tb.sv
module bitclk_recovery_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk, rst_n, din_raw, recov_dis;
  logic [6:0] rate_code;
  logic       data_out, dclk_out, bit_valid;
  int         n_chk, n_bad;

  // {rate code, data byte sent MSB first}
  localparam logic [14:0] VEC [4] = '{
    {7'd0, 8'hA5}, {7'd2, 8'h3C}, {7'd5, 8'hF0}, {7'd1, 8'h96}
  };

  bitclk_recovery u_dut (
    .clk(clk), .rst_n(rst_n), .din_raw(din_raw), .rate_code(rate_code),
    .recov_dis(recov_dis), .data_out(data_out), .dclk_out(dclk_out),
    .bit_valid(bit_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts negedges until the next rising edge of dclk_out
  task automatic wait_rise(output int n);
    logic p, hit;
    n = 0;
    p = dclk_out;
    do begin
      @(negedge clk);
      n++;
      hit = dclk_out && !p;
      p = dclk_out;
    end while (!hit);
  endtask

  task automatic period_at(input int d, input string req);
    int n;
    rate_code = 7'(d);
    wait_rise(n); wait_rise(n); wait_rise(n);
    wait_rise(n);
    check(req, n, 64 * (d + 1));
  endtask

  task automatic send_bit(input logic b, input string req);
    while (!dclk_out) @(negedge clk);
    while (dclk_out) @(negedge clk);
    repeat (2) @(negedge clk);
    din_raw = b;
    while (!bit_valid) @(negedge clk);
    check(req, int'(data_out), int'(b));
    check("R4 dclk high at valid", int'(dclk_out), 1);
    @(negedge clk);
    check("R4 valid one cycle", int'(bit_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, k;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; din_raw = 1'b0; recov_dis = 1'b0; rate_code = 7'd0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 dclk", int'(dclk_out), 0);
    check("R10 valid", int'(bit_valid), 0);
    check("R10 data", int'(data_out), 0);
    rst_n = 1'b1;

    // R5 table walk of rate codes and bytes
    foreach (VEC[i]) begin
      rate_code = VEC[i][14:8];
      for (int b = 7; b >= 0; b--) send_bit(VEC[i][b], "R5 retimed bit");
    end

    // R1 / R2 / R3 periods with steady input
    period_at(0, "R1 period D=0");
    period_at(3, "R1 period D=3");
    period_at(7, "R2 period D=7 (25kb/s)");
    k = 0;
    while (dclk_out) begin @(negedge clk); k++; end
    check("R3 high time D=7", k, 256);
    period_at(3, "R1 period D=3 again");
    wait_rise(n);
    k = 0;
    while (dclk_out) begin @(negedge clk); k++; end
    check("R3 high time D=3", k, 128);

    // R7 advance: transition in second half
    wait_rise(n);
    repeat (10) @(negedge clk);
    din_raw = ~din_raw;
    wait_rise(n);
    check("R7 advanced period", n + 10, 252);

    // R6 retard: transition in first half
    wait_rise(n);
    k = 0;
    while (dclk_out) begin @(negedge clk); k++; end
    repeat (10) @(negedge clk);
    din_raw = ~din_raw;
    wait_rise(n);
    check("R6 retarded period", k + 10 + n, 260);

    // R8 rate change at boundary
    period_at(0, "R1 period D=0 again");
    @(negedge clk);
    rate_code = 7'd3;
    wait_rise(n);
    check("R8 mixed period", n + 1, 160);

    // R9 bypass
    recov_dis = 1'b1;
    k = 0;
    for (int c = 0; c < 200; c++) begin
      if (c % 7 == 0) din_raw = ~din_raw;
      #1;
      if (data_out != din_raw || dclk_out || bit_valid) k++;
      @(negedge clk);
    end
    check("R9 bypass mismatch cycles", k, 0);
    din_raw = 1'b1; #1;
    check("R9 data follows raw 1", int'(data_out), 1);
    din_raw = 1'b0; #1;
    check("R9 data follows raw 0", int'(data_out), 0);
    recov_dis = 1'b0;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule